// File: doc/BRIEF.md
# Multiplexed LCD Drive Level Generator

This block produces the drive levels for a passive multiplexed LCD panel with one-third bias. It can scan either four or three common lines, and the choice can change while it runs. Each output pin carries a 2-bit level code: 0 is ground, 1 is one third of supply, 2 is two thirds and 3 is full supply. A separate analog stage turns these codes into voltages. The display bits come from a latch that is loaded elsewhere. A frame-rate tick steps the scan from one common line to the next.

Inputs that override the normal waveform are a segment blanking control, a power-save control and an active-low inhibit pin. A 3-bit code can also take over the first four segment pins, one at a time, and use them as static logic ports. Such a port drives either full supply or ground.

Top module: `lcd_mux_drive`

## Requirements
- R1: After reset the active common is common 0 and the polarity is the first half. With inhibit high and no override, common 0 then drives code 3 and the other commons drive code 1.
- R2: Each cycle with `frame_tick` high moves the active common up by one. When the active common is at or beyond the last common of the current mode, the tick returns it to common 0 and flips the polarity. Without a tick, the scan state holds.
- R3: The active common drives code 3 in the first half and code 0 in the second half. Every other common drives code 1 in the first half and code 2 in the second half.
- R4: With `three_com`=0, segment pin k uses display bits 4k..4k+3, one bit for each of commons 0..3. A lit segment (bit of the active common equal to 1) drives code 0 in the first half and code 3 in the second half. An unlit segment drives code 2 in the first half and code 1 in the second half.
- R5: With `three_com`=1, segment pin k uses bits 3k..3k+2. Common pin 3 becomes an extra segment that uses bits 3*NSEG..3*NSEG+2 and follows the lit and unlit rules of R4. If the active common index is 3 in this mode, it is treated as common 0.
- R6: `port_sel` sets `port_mode_o`: 000→0000, 001→0001, 010→0011, 011→0111, 100→1111, and 101/110/111→0000. Bit k marks segment pin k as a port.
- R7: A segment pin used as a port drives code 3 when the bit for its first common is 1 and code 0 when it is 0. That bit is 4k when `three_com`=0 and 3k when `three_com`=1.
- R8: When `seg_blank` is 1, every segment pin that is not a port drives the unlit levels, and the commons keep scanning.
- R9: When `power_save` is 1, every common and every non-port segment pin drives code 0, and port pins still follow their bits.
- R10: When `inhibit_n` is 0, every common and segment pin drives code 0 and `port_mode_o` is 1111. This overrides every other control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick | input | 1 | One-cycle pulse that steps the scan |
| disp_bits | input | 4*NSEG | Latched display bits |
| three_com | input | 1 | 0: four commons, 1: three commons plus an extra segment |
| seg_blank | input | 1 | Force all segments to the unlit waveform |
| power_save | input | 1 | Drive commons and segments to ground |
| inhibit_n | input | 1 | Active-low display inhibit |
| port_sel | input | 3 | Code that selects which shared pins are ports |
| com_lvl_o | output | 8 | Level codes of commons 0..3, two bits each, common 0 in the low bits |
| seg_lvl_o | output | 2*NSEG | Level codes of the segment pins, pin 0 in the low bits |
| port_mode_o | output | 4 | Bit k set: segment pin k is a logic port |

## Verification
The hardest case to reach is a switch from four to three commons while common 3 is active. The active index then lies outside the new mode. It must read as common 0, and the next tick must wrap the scan and flip the polarity. The stimulus ticks a four-common scan up to common 3, sets `three_com`, checks the levels on that same cycle and then ticks once more. The bench also walks all eight port codes in both modes with display bits chosen so that each port pin and its neighbours have different values.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;
    localparam int NCOM_MAX = 4;
    localparam int NPORT    = 4;

    localparam logic [1:0] LV_GND  = 2'd0;
    localparam logic [1:0] LV_THIRD = 2'd1;
    localparam logic [1:0] LV_TWO3 = 2'd2;
    localparam logic [1:0] LV_FULL = 2'd3;

    typedef struct packed {
        logic [1:0] phase;
        logic       half;
    } scan_t;

    function automatic logic [1:0] com_level(input logic sel, input logic half);
        if (sel) return half ? LV_GND : LV_FULL;
        return half ? LV_TWO3 : LV_THIRD;
    endfunction

    function automatic logic [1:0] seg_level(input logic lit, input logic half);
        if (lit) return half ? LV_FULL : LV_GND;
        return half ? LV_THIRD : LV_TWO3;
    endfunction
endpackage

// File: rtl/lcdw_scan.sv
module lcdw_scan
    import lcdw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       three_com,
    output logic [1:0] phase_o,
    output logic       half_o
);
    scan_t st_d, st_q;
    logic [1:0] last;

    always_comb begin
        last = three_com ? 2'd2 : 2'd3;
        st_d = st_q;
        if (tick) begin
            if (st_q.phase >= last) begin
                st_d.phase = 2'd0;
                st_d.half  = ~st_q.half;
            end else begin
                st_d.phase = st_q.phase + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_o = (three_com && st_q.phase == 2'd3) ? 2'd0 : st_q.phase;
    assign half_o  = st_q.half;

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q));
    p_wrap_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.phase >= last) |=> (st_q.phase == 2'd0 && st_q.half != $past(st_q.half)));
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.phase < last) |=> (st_q.phase == $past(st_q.phase) + 2'd1 && $stable(st_q.half)));
endmodule

// File: rtl/lcdw_port_map.sv
module lcdw_port_map
    import lcdw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       code,
    input  logic             inhibit_n,
    output logic [NPORT-1:0] mask_o
);
    always_comb begin
        mask_o = '0;
        if (!inhibit_n) begin
            mask_o = '1;
        end else if (code <= 3'(NPORT)) begin
            for (int k = 0; k < NPORT; k++)
                mask_o[k] = (k < int'(code));
        end
    end

    p_thermo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o & (mask_o + 1'b1)) == '0);
    p_fallback_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_n && code > 3'(NPORT)) |-> mask_o == '0);
endmodule

// File: rtl/lcdw_seg_drv.sv
module lcdw_seg_drv
    import lcdw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] grp,
    input  logic [1:0] phase,
    input  logic       half,
    input  logic       blank,
    input  logic       off,
    input  logic       inhibit_n,
    input  logic       port_en,
    output logic [1:0] lvl
);
    logic lit;

    always_comb begin
        lit = ~blank & grp[phase];
        if (port_en)  lvl = (grp[0] & inhibit_n) ? LV_FULL : LV_GND;
        else if (off) lvl = LV_GND;
        else          lvl = seg_level(lit, half);
    end

    p_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && !off && !port_en) |-> (lvl == LV_THIRD || lvl == LV_TWO3));
    p_port_static_r7: assert property (@(posedge clk) disable iff (!rst_n)
        port_en |-> (lvl == LV_FULL || lvl == LV_GND));
endmodule

// File: rtl/lcd_mux_drive.sv
module lcd_mux_drive
    import lcdw_pkg::*;
#(
    parameter int NSEG = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_tick,
    input  logic [4*NSEG-1:0]   disp_bits,
    input  logic                three_com,
    input  logic                seg_blank,
    input  logic                power_save,
    input  logic                inhibit_n,
    input  logic [2:0]          port_sel,
    output logic [2*NCOM_MAX-1:0] com_lvl_o,
    output logic [2*NSEG-1:0]   seg_lvl_o,
    output logic [NPORT-1:0]    port_mode_o
);
    localparam int DW = 4 * NSEG;

    logic [1:0] phase;
    logic       half;
    logic       off;
    logic [1:0] extra_lvl;
    logic [NCOM_MAX-1:0] com_drv;

    assign off = ~inhibit_n | power_save;

    lcdw_scan u_scan (
        .clk(clk), .rst_n(rst_n), .tick(frame_tick), .three_com(three_com),
        .phase_o(phase), .half_o(half)
    );

    lcdw_port_map u_map (
        .clk(clk), .rst_n(rst_n), .code(port_sel), .inhibit_n(inhibit_n),
        .mask_o(port_mode_o)
    );

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        logic [3:0] grp;
        assign grp = three_com ? {1'b0, disp_bits[3*k +: 3]} : disp_bits[4*k +: 4];
        lcdw_seg_drv u_drv (
            .clk(clk), .rst_n(rst_n), .grp(grp), .phase(phase), .half(half),
            .blank(seg_blank), .off(off), .inhibit_n(inhibit_n),
            .port_en((k < NPORT) ? port_mode_o[k] : 1'b0),
            .lvl(seg_lvl_o[2*k +: 2])
        );
    end

    lcdw_seg_drv u_extra (
        .clk(clk), .rst_n(rst_n), .grp({1'b0, disp_bits[3*NSEG +: 3]}),
        .phase(phase), .half(half), .blank(seg_blank), .off(off),
        .inhibit_n(inhibit_n), .port_en(1'b0), .lvl(extra_lvl)
    );

    for (genvar i = 0; i < NCOM_MAX; i++) begin : g_com
        logic [1:0] cl;
        assign cl = off ? LV_GND : com_level(phase == 2'(i), half);
        if (i == NCOM_MAX - 1) begin : g_shared
            assign com_lvl_o[2*i +: 2] = three_com ? extra_lvl : cl;
        end else begin : g_plain
            assign com_lvl_o[2*i +: 2] = cl;
        end
        assign com_drv[i] = (com_lvl_o[2*i +: 2] == LV_FULL) || (com_lvl_o[2*i +: 2] == LV_GND);
    end

    p_inhibit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit_n |-> (com_lvl_o == '0 && seg_lvl_o == '0 && port_mode_o == '1));
    p_psave_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_n && power_save) |-> com_lvl_o[5:0] == '0);
    p_one_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_n && !power_save && !three_com) |-> $countones(com_drv) == 1);
    p_one_sel3_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_n && !power_save && three_com) |-> $countones(com_drv[2:0]) == 1);
endmodule

// File: tb/sim_lcd_mux_drive.sv
module sim_lcd_mux_drive;
    localparam int CLK_P = 10;
    localparam int NSEG  = 6;
    localparam int DW    = 4 * NSEG;

    logic clk = 0, rst_n = 0, frame_tick = 0;
    logic [DW-1:0] disp_bits = '0;
    logic three_com = 0, seg_blank = 0, power_save = 0, inhibit_n = 1;
    logic [2:0] port_sel = 3'd0;
    logic [7:0] com_lvl_o;
    logic [2*NSEG-1:0] seg_lvl_o;
    logic [3:0] port_mode_o;

    lcd_mux_drive #(.NSEG(NSEG)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .disp_bits(disp_bits),
        .three_com(three_com), .seg_blank(seg_blank), .power_save(power_save),
        .inhibit_n(inhibit_n), .port_sel(port_sel), .com_lvl_o(com_lvl_o),
        .seg_lvl_o(seg_lvl_o), .port_mode_o(port_mode_o)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        logic [7:0]        c;
        logic [2*NSEG-1:0] s;
        logic [3:0]        p;
        string             tag;
    } item_t;

    item_t q[$];
    event chk_ev;
    int n_cmp = 0, n_bad = 0;
    int m_ph = 0;
    logic m_half = 0;

    function automatic logic [1:0] lv_com(bit sel, bit h);
        if (sel) return h ? 2'd0 : 2'd3;
        return h ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [1:0] lv_seg(bit lit, bit h);
        if (lit) return h ? 2'd3 : 2'd0;
        return h ? 2'd1 : 2'd2;
    endfunction

    task automatic expect_now(string tag);
        item_t it;
        int nc = three_com ? 3 : 4;
        int ep = (three_com && m_ph == 3) ? 0 : m_ph;
        bit off = !inhibit_n || power_save;
        it.tag = tag;
        if (!inhibit_n) it.p = 4'hF;
        else case (port_sel)
            3'd1: it.p = 4'b0001;
            3'd2: it.p = 4'b0011;
            3'd3: it.p = 4'b0111;
            3'd4: it.p = 4'b1111;
            default: it.p = 4'b0000;
        endcase
        for (int i = 0; i < 4; i++)
            it.c[2*i +: 2] = off ? 2'd0 : lv_com(i == ep, m_half);
        for (int k = 0; k < NSEG; k++) begin
            if (k < 4 && it.p[k])
                it.s[2*k +: 2] = (inhibit_n && disp_bits[k*nc]) ? 2'd3 : 2'd0;
            else if (off)
                it.s[2*k +: 2] = 2'd0;
            else
                it.s[2*k +: 2] = lv_seg(!seg_blank && disp_bits[k*nc + ep], m_half);
        end
        if (three_com)
            it.c[7:6] = off ? 2'd0 : lv_seg(!seg_blank && disp_bits[3*NSEG + ep], m_half);
        q.push_back(it);
        -> chk_ev;
        #2;
    endtask

    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_cmp++;
                if (com_lvl_o !== it.c || seg_lvl_o !== it.s || port_mode_o !== it.p) begin
                    n_bad++;
                    $display("FAIL %s: com=%h seg=%h port=%b expected com=%h seg=%h port=%b",
                             it.tag, com_lvl_o, seg_lvl_o, port_mode_o, it.c, it.s, it.p);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        frame_tick = 1;
        @(posedge clk);
        @(negedge clk);
        frame_tick = 0;
        if (m_ph >= (three_com ? 2 : 3)) begin
            m_ph = 0;
            m_half = ~m_half;
        end else m_ph++;
    endtask

    bit done = 0;

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        disp_bits = 24'hA5C396;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        expect_now("R1 reset state");
        // Full four-common scan over two polarities
        for (int t = 0; t < 8; t++) begin
            tick();
            expect_now("R2 R3 R4 four-common scan");
        end
        disp_bits = 24'h3C5A0F;
        expect_now("R4 new pattern");
        tick(); tick(); tick();
        expect_now("R4 common 3 active");
        // Switch to three commons while common 3 is active
        three_com = 1;
        expect_now("R5 out-of-range index reads as common 0");
        tick();
        expect_now("R2 wrap after mode switch");
        disp_bits = 24'h96E1B7;
        for (int t = 0; t < 6; t++) begin
            tick();
            expect_now("R5 three-common scan");
        end
        // Port codes in both modes
        for (int m = 0; m < 2; m++) begin
            three_com = m[0];
            disp_bits = m ? 24'h000249 : 24'h001111;
            for (int c = 0; c < 8; c++) begin
                port_sel = 3'(c);
                expect_now("R6 R7 port code");
            end
            disp_bits = ~disp_bits;
            port_sel = 3'd4;
            expect_now("R7 inverted port data");
            tick();
            expect_now("R7 ports static across tick");
        end
        port_sel = 3'd2;
        three_com = 0;
        disp_bits = 24'hFFFFFF;
        seg_blank = 1;
        expect_now("R8 blank all lit");
        tick();
        expect_now("R8 blank commons scanning");
        seg_blank = 0;
        power_save = 1;
        expect_now("R9 power save");
        tick();
        expect_now("R9 power save after tick");
        power_save = 0;
        inhibit_n = 0;
        port_sel = 3'd0;
        expect_now("R10 inhibit");
        seg_blank = 1;
        port_sel = 3'd6;
        tick();
        expect_now("R10 inhibit overrides");
        inhibit_n = 1;
        seg_blank = 0;
        expect_now("R10 release");
        done = 1;
        #5;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule